// File: doc/BRIEF.md
# Single-Channel DMA Transfer Controller

This block moves a block of bytes between a peripheral and a byte-wide memory bus without the CPU handling each byte. The CPU programs a start address, a byte count and a control word through a small register port. The peripheral asks for service on `dreq`. The controller then either borrows the bus from the CPU through a `hold`/`hlda` handshake or, in interleaved mode, slips bytes into cycles where the CPU reports its bus idle. Once it owns the bus, it grants the peripheral with `dack` and drives the memory address together with one read or write strobe per byte.

Three transfer modes exist. Block mode keeps the bus for the whole count, one byte per cycle. Cycle-steal mode takes the bus for exactly one byte and then gives it back. In that byte cycle it also pulls `inhibit` low, so that an external AND with the system clock stalls the CPU. Interleaved mode never raises `hold`. It moves a byte only in a cycle where `bus_idle` is high.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: When `dreq` is seen while the count is nonzero in block or cycle-steal mode, `hold` goes high in the next cycle, and neither `dack` nor any memory strobe is driven while `hlda` is low.
- R2: `dack` and a memory strobe appear only once `hlda` is high, with one strobe per byte and one byte per cycle in block mode. Control bit 4 selects the direction: 0 drives `mem_rd` (memory to peripheral) and 1 drives `mem_wr` (peripheral to memory). The two strobes are never high together.
- R3: The first byte uses the programmed address. The address rises by 1 after every byte and wraps at the top of the address range.
- R4: The count register falls by 1 after every byte. The transfer ends after exactly the programmed number of bytes, and the count register then reads 0.
- R5: In the cycle after the last byte, `hold` and `dack` are low, status reads done=1 and busy=0.
- R6: The value of `reg_sel` picks a register: 0 is the address, 1 is the count, 2 is control/status. Control/status reads done in bit 0, busy in bit 1, the mode in bits 3:2 (0 block, 1 cycle-steal, 2 interleaved) and the direction in bit 4. Writes to register 2 set the mode and direction from those same bits.
- R7: Writing the count register clears the done flag.
- R8: In cycle-steal mode, each `hold`/`hlda` acquisition moves exactly one byte. `inhibit` is low exactly in those byte cycles and high at all other times and in all other modes.
- R9: In interleaved mode, `hold` stays low, and a byte moves only in a cycle where `bus_idle` is high.
- R10: A request that arrives with a count of zero sets done at once, without raising `hold` or driving any strobe.
- R11: Register writes made while busy have no effect on the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 2 | Register select: 0 address, 1 count, 2 control/status |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data of the selected register, combinational |
| dreq | input | 1 | Peripheral transfer request |
| dack | output | 1 | Peripheral acknowledge, high during each byte cycle |
| hold | output | 1 | Bus request to the CPU |
| hlda | input | 1 | Bus grant from the CPU |
| bus_idle | input | 1 | CPU reports that it is not using the bus this cycle |
| inhibit | output | 1 | Active-high CPU clock enable, low during a stolen cycle |
| mem_addr | output | ADDR_W | Memory address of the current byte |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |

## Verification
The in-design assertions check the following on every cycle:
- no strobe is driven under `hold` without `hlda`;
- interleaved bytes fall only on idle cycles;
- a low `inhibit` lasts one cycle and only during a stolen byte;
- the address and the count move by exactly one per byte;
- the bus is released right after the last byte;
- a count write clears done.

Other behaviour needs whole scenarios in the bench: the total number of bytes, the address sequence across the wrap, the number of bus acquisitions in each mode, the register readback, and the fact that writes made while busy leave the transfer unchanged.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    typedef enum logic [1:0] {
        XM_BLOCK = 2'd0,
        XM_STEAL = 2'd1,
        XM_INTLV = 2'd2
    } xfer_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_MOVE,
        ST_SNEAK
    } seq_state_e;

    localparam logic [1:0] SEL_ADDR  = 2'd0;
    localparam logic [1:0] SEL_COUNT = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;

    localparam int unsigned BIT_DONE = 0;
    localparam int unsigned BIT_BUSY = 1;
    localparam int unsigned BIT_MODE = 2;
    localparam int unsigned BIT_DIR  = 4;
endpackage

// File: rtl/dmac_regs.sv
module dmac_regs
    import dmac_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_sel,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              busy,
    input  logic              step,
    input  logic              finish,
    output logic [ADDR_W-1:0] addr,
    output logic [1:0]        mode,
    output logic              dir,
    output logic              cnt_zero,
    output logic              cnt_last
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic [1:0]        mode;
        logic              dir;
        logic              done;
    } regs_t;

    regs_t r_q, r_d;
    logic  wr_ok;

    assign wr_ok = reg_wr && !busy;

    always_comb begin
        r_d = r_q;
        if (wr_ok) begin
            case (reg_sel)
                SEL_ADDR:  r_d.addr = reg_wdata[ADDR_W-1:0];
                SEL_COUNT: begin
                    r_d.cnt  = reg_wdata[CNT_W-1:0];
                    r_d.done = 1'b0;
                end
                SEL_CTRL: begin
                    r_d.mode = reg_wdata[BIT_MODE+1:BIT_MODE];
                    r_d.dir  = reg_wdata[BIT_DIR];
                end
                default: ;
            endcase
        end
        if (step) begin
            r_d.addr = r_q.addr + ADDR_W'(1);
            r_d.cnt  = r_q.cnt - CNT_W'(1);
        end
        if (finish) r_d.done = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_ADDR:  reg_rdata[ADDR_W-1:0] = r_q.addr;
            SEL_COUNT: reg_rdata[CNT_W-1:0]  = r_q.cnt;
            SEL_CTRL: begin
                reg_rdata[BIT_DONE]              = r_q.done;
                reg_rdata[BIT_BUSY]              = busy;
                reg_rdata[BIT_MODE+1:BIT_MODE]   = r_q.mode;
                reg_rdata[BIT_DIR]               = r_q.dir;
            end
            default: ;
        endcase
    end

    assign addr     = r_q.addr;
    assign mode     = r_q.mode;
    assign dir      = r_q.dir;
    assign cnt_zero = (r_q.cnt == '0);
    assign cnt_last = (r_q.cnt == CNT_W'(1));

    assert_addr_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> r_q.addr == $past(r_q.addr) + ADDR_W'(1));

    assert_cnt_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> r_q.cnt == $past(r_q.cnt) - CNT_W'(1));

    assert_count_clears_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && reg_sel == SEL_COUNT && !finish) |=> !r_q.done);

    assert_busy_mode_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> r_q.mode == $past(r_q.mode) && r_q.dir == $past(r_q.dir));
endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
    import dmac_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dreq,
    input  logic       hlda,
    input  logic       bus_idle,
    input  logic [1:0] mode,
    input  logic       dir,
    input  logic       cnt_zero,
    input  logic       cnt_last,
    output logic       hold,
    output logic       dack,
    output logic       mem_rd,
    output logic       mem_wr,
    output logic       inhibit,
    output logic       busy,
    output logic       step,
    output logic       finish
);
    typedef struct packed {
        seq_state_e state;
    } seq_t;

    seq_t s_q, s_d;

    always_comb begin
        s_d    = s_q;
        step   = 1'b0;
        finish = 1'b0;
        case (s_q.state)
            ST_IDLE: begin
                if (dreq) begin
                    if (cnt_zero)              finish = 1'b1;
                    else if (mode == XM_INTLV) s_d.state = ST_SNEAK;
                    else                       s_d.state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (hlda) s_d.state = ST_MOVE;
            end
            ST_MOVE: begin
                step = 1'b1;
                if (cnt_last) begin
                    finish    = 1'b1;
                    s_d.state = ST_IDLE;
                end else if (mode == XM_STEAL) begin
                    s_d.state = ST_IDLE;
                end
            end
            ST_SNEAK: begin
                if (bus_idle) begin
                    step = 1'b1;
                    if (cnt_last) begin
                        finish    = 1'b1;
                        s_d.state = ST_IDLE;
                    end
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{state: ST_IDLE};
        else        s_q <= s_d;
    end

    assign hold    = (s_q.state == ST_WAIT) || (s_q.state == ST_MOVE);
    assign dack    = (s_q.state == ST_MOVE) || ((s_q.state == ST_SNEAK) && bus_idle);
    assign mem_rd  = dack && !dir;
    assign mem_wr  = dack && dir;
    assign inhibit = !((s_q.state == ST_MOVE) && (mode == XM_STEAL));
    assign busy    = (s_q.state != ST_IDLE);

    assert_grant_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !hlda && s_q.state == ST_WAIT) |-> !(mem_rd || mem_wr));

    assert_strobe_needs_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dack && hold) |-> hlda);

    assert_release_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && finish) |=> !hold && !dack);

    assert_inhibit_only_steal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !inhibit |-> (dack && hold && mode == XM_STEAL));

    assert_single_steal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !inhibit |=> inhibit);

    assert_intlv_idle_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dack && !hold) |-> bus_idle);

    assert_zero_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && !step) |=> !hold && !mem_rd && !mem_wr);
endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl
    import dmac_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_sel,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              dreq,
    output logic              dack,
    output logic              hold,
    input  logic              hlda,
    input  logic              bus_idle,
    output logic              inhibit,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr
);
    logic       busy, step, finish, dir, cnt_zero, cnt_last;
    logic [1:0] mode;

    dmac_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .step      (step),
        .finish    (finish),
        .addr      (mem_addr),
        .mode      (mode),
        .dir       (dir),
        .cnt_zero  (cnt_zero),
        .cnt_last  (cnt_last)
    );

    dmac_seq seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .dreq     (dreq),
        .hlda     (hlda),
        .bus_idle (bus_idle),
        .mode     (mode),
        .dir      (dir),
        .cnt_zero (cnt_zero),
        .cnt_last (cnt_last),
        .hold     (hold),
        .dack     (dack),
        .mem_rd   (mem_rd),
        .mem_wr   (mem_wr),
        .inhibit  (inhibit),
        .busy     (busy),
        .step     (step),
        .finish   (finish)
    );
endmodule

// File: tb/dma_xfer_ctrl_tb_top.sv
module dma_xfer_ctrl_tb_top;
    localparam int ADDR_W = 16;
    localparam int CNT_W  = 16;
    localparam int REG_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        reg_sel = 2'd0;
    logic              reg_wr = 1'b0;
    logic [REG_W-1:0]  reg_wdata = '0;
    logic [REG_W-1:0]  reg_rdata;
    logic              dreq = 1'b0;
    logic              dack, hold, inhibit, mem_rd, mem_wr;
    logic              hlda = 1'b0;
    logic              bus_idle = 1'b0;
    logic [ADDR_W-1:0] mem_addr;

    int checks = 0;
    int errors = 0;

    // CPU model and monitor state
    int lat = 0;
    int hold_cyc = 0;
    int n_rd, n_wr, n_acq, n_inh, n_badaddr, n_badgrant, n_badidle;
    logic [ADDR_W-1:0] exp_addr;
    logic prev_hold = 1'b0;

    always #4 clk = ~clk;

    dma_xfer_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq), .dack(dack),
        .hold(hold), .hlda(hlda), .bus_idle(bus_idle), .inhibit(inhibit),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [REG_W-1:0] ctrl_word(input int mode, input bit dir);
        logic [REG_W-1:0] w = '0;
        w[3:2] = mode[1:0];
        w[4]   = dir;
        return w;
    endfunction

    // CPU: grants the bus lat cycles after hold, drops grant with hold
    initial forever begin
        @(negedge clk);
        if (hold) begin
            hold_cyc++;
            hlda = (hold_cyc > lat);
        end else begin
            hold_cyc = 0;
            hlda = 1'b0;
        end
        bus_idle = (($urandom % 3) != 0);
    end

    // Bus monitor
    initial forever begin
        @(negedge clk);
        #1;
        if (rst_n) begin
            if (hold && !prev_hold) n_acq++;
            prev_hold = hold;
            if (!inhibit) n_inh++;
            if (mem_rd || mem_wr) begin
                if (mem_rd) n_rd++;
                if (mem_wr) n_wr++;
                if (mem_rd && mem_wr) n_badgrant++;
                if (!dack) n_badgrant++;
                if (hold && !hlda) n_badgrant++;
                if (!hold && !bus_idle) n_badidle++;
                if (mem_addr != exp_addr) n_badaddr++;
                exp_addr = exp_addr + 1'b1;
            end else if (dack || (hold && !hlda && dack)) begin
                n_badgrant++;
            end
        end
    end

    task automatic reg_write(input logic [1:0] sel, input logic [REG_W-1:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] sel, output logic [REG_W-1:0] d);
        reg_sel = sel;
        #1;
        d = reg_rdata;
    endtask

    task automatic clear_mon(input logic [ADDR_W-1:0] start);
        n_rd = 0; n_wr = 0; n_acq = 0; n_inh = 0;
        n_badaddr = 0; n_badgrant = 0; n_badidle = 0;
        exp_addr = start;
    endtask

    task automatic run_xfer(input int mode, input bit dir, input logic [ADDR_W-1:0] start,
                            input int n, input int latency, input bit poke);
        logic [REG_W-1:0] rd;
        int waited;
        lat = latency;
        reg_write(2'd0, REG_W'(start));
        reg_write(2'd1, REG_W'(n));
        reg_write(2'd2, ctrl_word(mode, dir));
        @(negedge clk); #2;
        reg_read(2'd0, rd);
        chk(rd == REG_W'(start), "R6 addr readback", int'(rd), int'(start));
        reg_read(2'd1, rd);
        chk(rd == REG_W'(n), "R6 count readback", int'(rd), n);
        reg_read(2'd2, rd);
        chk(rd[4:2] == {dir, 2'(mode)} && rd[1:0] == 2'b00, "R6 R7 ctrl readback",
            int'(rd[4:0]), int'({dir, 2'(mode), 2'b00}));
        clear_mon(start);
        @(negedge clk);
        dreq = 1'b1;
        @(negedge clk); #2;
        if (mode == 2) chk(!hold, "R9 no hold in interleaved", int'(hold), 0);
        else chk(hold && !dack, "R1 hold before ack", int'({hold, dack}), 2);
        if (poke) begin
            reg_write(2'd0, 16'hBEEF);
            reg_write(2'd1, 16'd3);
            reg_write(2'd2, ctrl_word(mode == 0 ? 1 : 0, !dir));
        end
        waited = 0;
        rd = '0;
        while (!rd[0] && waited < 4000) begin
            @(negedge clk); #2;
            reg_read(2'd2, rd);
            waited++;
        end
        dreq = 1'b0;
        chk(rd[1:0] == 2'b01, "R5 status done not busy", int'(rd[1:0]), 1);
        chk(!hold && !dack, "R5 bus released", int'({hold, dack}), 0);
        chk((dir ? n_wr : n_rd) == n && (dir ? n_rd : n_wr) == 0,
            "R2 R4 strobe count and direction", dir ? n_wr : n_rd, n);
        chk(n_badaddr == 0, "R3 address sequence", n_badaddr, 0);
        chk(n_badgrant == 0, "R1 R2 strobe without grant", n_badgrant, 0);
        reg_read(2'd1, rd);
        chk(rd == '0, "R4 count ends at zero", int'(rd), 0);
        reg_read(2'd0, rd);
        chk(rd == REG_W'(start + ADDR_W'(n)), "R3 final address", int'(rd),
            int'(ADDR_W'(start + ADDR_W'(n))));
        case (mode)
            0: begin
                chk(n_acq == 1, "R2 block single acquisition", n_acq, 1);
                chk(n_inh == 0, "R8 inhibit idle in block", n_inh, 0);
            end
            1: begin
                chk(n_acq == n, "R8 one byte per acquisition", n_acq, n);
                chk(n_inh == n, "R8 inhibit per stolen byte", n_inh, n);
            end
            default: begin
                chk(n_acq == 0, "R9 hold never raised", n_acq, 0);
                chk(n_badidle == 0, "R9 bytes only on idle", n_badidle, 0);
                chk(n_inh == 0, "R8 inhibit idle in interleaved", n_inh, 0);
            end
        endcase
        if (poke) begin
            reg_read(2'd2, rd);
            chk(rd[4:2] == {dir, 2'(mode)}, "R11 ctrl kept while busy",
                int'(rd[4:2]), int'({dir, 2'(mode)}));
        end
    endtask

    initial begin
        logic [REG_W-1:0] rd;
        void'($urandom(32'h5EED_0042));
        clear_mon('0);
        repeat (3) @(negedge clk);
        #2;
        reg_read(2'd2, rd);
        chk(rd == '0, "R6 reset status", int'(rd), 0);
        chk(!hold && !dack && inhibit && !mem_rd && !mem_wr, "R8 reset outputs",
            int'({hold, dack, inhibit, mem_rd, mem_wr}), 4);
        rst_n = 1'b1;

        // directed corners
        run_xfer(0, 1'b0, 16'h0100, 5, 2, 1'b0);
        run_xfer(0, 1'b1, 16'hFFFE, 4, 0, 1'b0);   // R3 wrap
        run_xfer(1, 1'b0, 16'h2000, 3, 1, 1'b0);
        run_xfer(2, 1'b1, 16'h3000, 6, 0, 1'b0);
        run_xfer(0, 1'b0, 16'h4000, 1, 3, 1'b0);
        run_xfer(0, 1'b1, 16'h5000, 4, 6, 1'b1);   // R11 writes while busy

        // R7: count write clears done
        reg_write(2'd1, 16'd2);
        @(negedge clk); #2;
        reg_read(2'd2, rd);
        chk(rd[0] == 1'b0, "R7 done cleared by count write", int'(rd[0]), 0);

        // R10: zero count
        reg_write(2'd1, 16'd0);
        clear_mon(16'h0);
        @(negedge clk);
        dreq = 1'b1;
        repeat (4) @(negedge clk);
        dreq = 1'b0;
        #2;
        reg_read(2'd2, rd);
        chk(rd[1:0] == 2'b01, "R10 zero count done", int'(rd[1:0]), 1);
        chk(n_acq == 0 && n_rd == 0 && n_wr == 0, "R10 zero count no bus activity",
            n_acq + n_rd + n_wr, 0);

        // random runs
        for (int i = 0; i < 14; i++) begin
            run_xfer(int'($urandom % 3), 1'($urandom % 2), ADDR_W'($urandom),
                     1 + int'($urandom % 20), int'($urandom % 4), 1'b0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule